// File: doc/BRIEF.md
# Debug Unit Control and Comparator Register File

This block is the byte-wide register file that sits in front of an on-chip debug unit. It holds one control register and four comparator banks of eight bytes each. All four banks share one 8-byte address window. A two-bit visibility field in the control register picks the bank that the window reads and writes. A host reaches the block over a plain byte bus: address, write data, write strobe, read strobe and read data. Read data is combinational.

The control register contains an arm bit, a write-only trigger request, a secondary-core breakpoint enable, a debug-mode select, a two-bit break field and the visibility field. The arm bit is the block's only state. There are two states:

- `ST_IDLE`: the unit is disarmed. Every bit is writable.
- `ST_ARMED`: the unit is armed. Only the arm bit, the trigger request and the visibility field accept writes.

There are two transitions. `ARM_SET` is a control write with bit 7 set while in `ST_IDLE`. `DISARM` is a control write with bit 7 clear while in `ST_ARMED`. The write that disarms is still treated as locked, so the bits it carries for the locked fields are discarded. Writing 1 to the trigger bit gives a single-cycle pulse. The decoded fields and the stored contents of every bank drive the comparator logic downstream.

Top module: `dbg_regfile`

## Requirements
- R1: After reset, every control field, every bank byte and `trig_o` are 0.
- R2: The control register is at offset 0x20 and reads back as {arm, 0, xbrk_en, dbg_mode, brk_sel[1:0], vis_sel[1:0]}, from bit 7 down to bit 0. A write updates the outputs on the next clock edge.
- R3: A control write with bit 6 set drives `trig_o` high for exactly the following cycle and stores nothing. Bit 6 always reads 0.
- R4: The arm bit (bit 7) and vis_sel (bits 1:0) take the written value on every control write, armed or not.
- R5: Bits 5:2 are written only when the unit is disarmed before the write. A write that clears the arm bit leaves them unchanged, and a second write is needed to change them.
- R6: Offsets 0x28 to 0x2F read and write byte k = offset−0x28 of the bank chosen by vis_sel. Byte k of bank b appears on `bank_o[b*64 + k*8 +: 8]`.
- R7: While the unit is armed, writes to the window are ignored.
- R8: Offsets outside 0x20 and 0x28 to 0x2F read as 0, and writes to them change nothing. `bus_rdata` is 0 whenever `bus_rd` is low.
- R9: `bus_rdata` reflects the state in the same cycle that `bus_rd` and `bus_addr` are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| arm_o | output | 1 | Unit armed |
| xbrk_en_o | output | 1 | Secondary-core breakpoint enable |
| dbg_mode_o | output | 1 | Debug-mode select |
| brk_sel_o | output | 2 | Break field |
| vis_sel_o | output | 2 | Bank shown in the window |
| trig_o | output | 1 | Single-cycle trigger pulse |
| bank_o | output | 256 | Contents of all four banks |

## Verification
The assertions assume that `bus_wr` and its address and data are stable across each sampling edge. They also assume the strobes are low while reset is held, so the `$past` terms seen just after reset refer to idle inputs. The stimulus changes inputs one time unit after each rising edge and keeps the strobes low throughout reset. It also sends back-to-back control writes so that the lock, the disarming write and repeated triggers are each seen on consecutive edges.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } dbg_state_e;

    typedef struct packed {
        logic       xbrk_en;
        logic       dbg_mode;
        logic [1:0] brk_sel;
    } dbg_lockf_t;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
    import dbg_pkg::*;
#(
    parameter int unsigned VIS_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic [BYTE_W-1:0]    wdata,
    output logic                 armed,
    output dbg_lockf_t           fields,
    output logic [VIS_W-1:0]     vis,
    output logic                 trig
);

    dbg_state_e state_q, state_d;
    dbg_lockf_t fields_q;
    logic [VIS_W-1:0] vis_q;
    logic trig_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ctrl_wr && wdata[7])  state_d = ST_ARMED;
            ST_ARMED: if (ctrl_wr && !wdata[7]) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= '0;
            vis_q    <= '0;
            trig_q   <= 1'b0;
        end else begin
            trig_q <= ctrl_wr & wdata[6];
            if (ctrl_wr) begin
                vis_q <= wdata[VIS_W-1:0];
                if (state_q == ST_IDLE) fields_q <= wdata[5:2];
            end
        end
    end

    assign armed  = (state_q == ST_ARMED);
    assign fields = fields_q;
    assign vis    = vis_q;
    assign trig   = trig_q;

    // R5: locked fields hold across any edge taken while armed
    a_r5_fields_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |=> $stable(fields_q));

    // R3: a pulse always comes from a trigger write one cycle earlier
    a_r3_trig_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> $past(ctrl_wr && wdata[6]));

    // R4: the arm bit follows every control write
    a_r4_arm_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (armed == $past(wdata[7])));

endmodule

// File: rtl/dbg_bank_file.sv
module dbg_bank_file
    import dbg_pkg::*;
#(
    parameter int unsigned NBANK     = 4,
    parameter int unsigned WIN_BYTES = 8,
    localparam int unsigned VIS_W    = $clog2(NBANK),
    localparam int unsigned IDX_W    = $clog2(WIN_BYTES),
    localparam int unsigned FLAT_W   = NBANK * WIN_BYTES * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 win_wr,
    input  logic                 lock,
    input  logic [VIS_W-1:0]     vis,
    input  logic [IDX_W-1:0]     idx,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [BYTE_W-1:0]    rd_byte,
    output logic [FLAT_W-1:0]    bank_flat
);

    logic [BYTE_W-1:0] mem_q [NBANK][WIN_BYTES];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar k = 0; k < WIN_BYTES; k++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem_q[b][k] <= '0;
                else if (win_wr && !lock && vis == VIS_W'(b) && idx == IDX_W'(k))
                    mem_q[b][k] <= wdata;
            end
            assign bank_flat[(b*WIN_BYTES + k)*BYTE_W +: BYTE_W] = mem_q[b][k];
        end
    end

    assign rd_byte = mem_q[vis][idx];

    // R7: no bank byte changes across an edge taken while armed
    a_r7_window_locked: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(bank_flat));

    // R6: an unlocked window write lands in the selected bank and byte
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && !lock) |=>
        (bank_flat[({1'b0, $past(vis)} * WIN_BYTES + $past(idx)) * BYTE_W +: BYTE_W] == $past(wdata)));

endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
    import dbg_pkg::*;
#(
    parameter int unsigned  ADDR_W    = 6,
    parameter int unsigned  NBANK     = 4,
    parameter int unsigned  WIN_BYTES = 8,
    parameter logic [5:0]   CTRL_ADDR = 6'h20,
    parameter logic [5:0]   WIN_ADDR  = 6'h28,
    localparam int unsigned VIS_W     = $clog2(NBANK),
    localparam int unsigned IDX_W     = $clog2(WIN_BYTES),
    localparam int unsigned FLAT_W    = NBANK * WIN_BYTES * BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [BYTE_W-1:0]   bus_rdata,
    output logic                arm_o,
    output logic                xbrk_en_o,
    output logic                dbg_mode_o,
    output logic [1:0]          brk_sel_o,
    output logic [VIS_W-1:0]    vis_sel_o,
    output logic                trig_o,
    output logic [FLAT_W-1:0]   bank_o
);

    logic       hit_ctrl, hit_win;
    logic       armed;
    dbg_lockf_t fields;
    logic [VIS_W-1:0]  vis;
    logic [BYTE_W-1:0] win_byte;

    assign hit_ctrl = (bus_addr == CTRL_ADDR[ADDR_W-1:0]);
    assign hit_win  = (bus_addr[ADDR_W-1:IDX_W] == WIN_ADDR[ADDR_W-1:IDX_W]);

    dbg_ctrl #(.VIS_W(VIS_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (bus_wr && hit_ctrl),
        .wdata   (bus_wdata),
        .armed   (armed),
        .fields  (fields),
        .vis     (vis),
        .trig    (trig_o)
    );

    dbg_bank_file #(.NBANK(NBANK), .WIN_BYTES(WIN_BYTES)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_wr    (bus_wr && hit_win),
        .lock      (armed),
        .vis       (vis),
        .idx       (bus_addr[IDX_W-1:0]),
        .wdata     (bus_wdata),
        .rd_byte   (win_byte),
        .bank_flat (bank_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_ctrl)
                bus_rdata = {armed, 1'b0, fields.xbrk_en, fields.dbg_mode,
                             fields.brk_sel, vis};
            else if (hit_win)
                bus_rdata = win_byte;
        end
    end

    assign arm_o      = armed;
    assign xbrk_en_o  = fields.xbrk_en;
    assign dbg_mode_o = fields.dbg_mode;
    assign brk_sel_o  = fields.brk_sel;
    assign vis_sel_o  = vis;

    // R8: a write to an unmapped offset leaves every stored bit alone
    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit_ctrl && !hit_win) |=>
        ($stable(bank_o) && $stable(fields) && $stable(vis)));

    // R1: state just after reset release is all zero
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (!arm_o && !trig_o && bank_o == '0 && vis_sel_o == '0));

endmodule

// File: tb/dbg_regfile_tb_top.sv
module dbg_regfile_tb_top;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [7:0]   bus_wdata = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_rdata;
    logic         arm_o, xbrk_en_o, dbg_mode_o, trig_o;
    logic [1:0]   brk_sel_o, vis_sel_o;
    logic [255:0] bank_o;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .arm_o(arm_o), .xbrk_en_o(xbrk_en_o), .dbg_mode_o(dbg_mode_o),
        .brk_sel_o(brk_sel_o), .vis_sel_o(vis_sel_o), .trig_o(trig_o),
        .bank_o(bank_o)
    );

    // behavioural reference
    bit [7:0] m_bank [4][8];
    bit       m_arm;
    bit [3:0] m_f;
    bit [1:0] m_vis;
    bit       m_trig;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_bank[b, k]) m_bank[b][k] = 8'h00;
            m_arm = 0; m_f = 0; m_vis = 0; m_trig = 0;
        end else begin
            m_trig = bus_wr && bus_addr == 6'h20 && bus_wdata[6];
            if (bus_wr) begin
                if (bus_addr == 6'h20) begin
                    if (!m_arm) m_f = bus_wdata[5:2];
                    m_arm = bus_wdata[7];
                    m_vis = bus_wdata[1:0];
                end else if (bus_addr >= 6'h28 && bus_addr <= 6'h2F && !m_arm) begin
                    m_bank[m_vis][bus_addr - 6'h28] = bus_wdata;
                end
            end
        end
    end

    function automatic logic [7:0] exp_rdata();
        if (!bus_rd) return 8'h00;
        if (bus_addr == 6'h20) return {m_arm, 1'b0, m_f, m_vis};
        if (bus_addr >= 6'h28 && bus_addr <= 6'h2F) return m_bank[m_vis][bus_addr - 6'h28];
        return 8'h00;
    endfunction

    function automatic logic [255:0] exp_banks();
        logic [255:0] v;
        for (int b = 0; b < 4; b++)
            for (int k = 0; k < 8; k++)
                v[(b*8+k)*8 +: 8] = m_bank[b][k];
        return v;
    endfunction

    task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        check("R4 arm", 256'(arm_o), 256'(m_arm));
        check("R4 vis_sel", 256'(vis_sel_o), 256'(m_vis));
        check("R5 fields", 256'({xbrk_en_o, dbg_mode_o, brk_sel_o}), 256'(m_f));
        check("R3 trig", 256'(trig_o), 256'(m_trig));
        check("R6/R7 banks", bank_o, exp_banks());
        check("R2/R8/R9 rdata", 256'(bus_rdata), 256'(exp_rdata()));
        if (!rst_n)
            check("R1 reset", {arm_o, trig_o, vis_sel_o, bank_o != '0}, '0);
    end

    // drivers: called one time unit after a rising edge
    task automatic wr(logic [5:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rd_all();
        rd(6'h20);
        for (int k = 0; k < 8; k++) rd(6'(6'h28 + k));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R2/R5: fill fields while disarmed, then R6 each bank
        for (int b = 0; b < 4; b++) begin
            wr(6'h20, 8'h3C | 8'(b));
            for (int k = 0; k < 8; k++) wr(6'(6'h28 + k), 8'(8'h11 * (b + 1) + k));
            rd_all();
        end
        // ARM_SET with fields in the same write
        wr(6'h20, 8'h95);
        rd_all();
        // R5/R4: armed, fields ignored, vis changes
        wr(6'h20, 8'hAA);
        // R7: window writes ignored
        for (int k = 0; k < 8; k++) wr(6'(6'h28 + k), 8'hEE);
        rd_all();
        // R3: trigger while armed, back to back
        wr(6'h20, 8'hC2);
        wr(6'h20, 8'hC3);
        rd(6'h20);
        // DISARM with different field bits: R5 keeps old fields
        wr(6'h20, 8'h3F);
        rd(6'h20);
        wr(6'h20, 8'h3B);
        rd(6'h20);
        // R3 trigger while disarmed
        wr(6'h20, 8'h40);
        // R8: unmapped offsets
        wr(6'h21, 8'hFF);
        wr(6'h00, 8'hFF);
        wr(6'h27, 8'hFF);
        wr(6'h30, 8'hFF);
        wr(6'h3F, 8'hFF);
        rd(6'h21); rd(6'h27); rd(6'h30); rd(6'h3F);
        // R6: window live again, bank 2 and 3
        wr(6'h20, 8'h02);
        wr(6'h2F, 8'h5A);
        wr(6'h20, 8'h03);
        wr(6'h28, 8'hA5);
        rd_all();
        wr(6'h20, 8'h02);
        rd_all();
        repeat (3) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule